// File: doc/BRIEF.md
# Display Register Command Decoder

This block sits behind the transport of a display adapter and takes in a stream of bulk command bytes, one byte per accepted handshake. Every command opens with a marker byte and an operation byte. Register-write commands set an 8-bit display register. Copy commands are consumed and counted, and no memory is touched. A lone marker byte is harmless filler. The decoder keeps two register banks. A staged (shadow) bank takes every write. A live (active) bank drives the display timing.

A control write can freeze the live bank (lock). While the bank is locked, a whole video mode can be staged without the display ever seeing a half-written set of values. The matching release write (unlock) copies the whole staged bank into the live bank in one cycle and raises a one-cycle commit pulse. The live bank is presented as a flat vector. Several multi-byte quantities are also decoded from it: the colour-depth selector, the active width and height, the pixel clock and the two framebuffer base pointers. The pixel clock is stored with its bytes in the opposite order from the other fields. A sticky error flag reports malformed input.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After reset the live bank is all zero, `commit` and `proto_err` are 0, `copy_count` is 0 and `in_ready` is 1.
- R2: With the bank unlocked, the sequence 0xAF, 0x20, index, value writes value into both banks at that index. The change is visible on `act_regs[index*8 +: 8]` in the cycle after the value byte is accepted.
- R3: A register write to index 0xFF with value 0x00 locks the bank. After that, register writes reach only the staged bank and `act_regs` does not change.
- R4: A register write to index 0xFF with value 0xFF unlocks the bank and copies the whole staged bank into the live bank. In the cycle after the value byte, `commit` is 1 for exactly one cycle. `commit` is never raised at any other time.
- R5: The decoded fields are taken from the live bank with the high byte at the lower index: `depth_sel` = reg 0x00, `h_active` = {0x0F,0x10}, `v_active` = {0x17,0x18}, `base16` = {0x20,0x21,0x22} and `base8` = {0x26,0x27,0x28}.
- R6: `pixclk_5k` = {reg 0x1C, reg 0x1B}, so the low byte is at 0x1B.
- R7: The sequence 0xAF, 0x6A followed by 7 argument bytes is a copy command. The argument bytes are never decoded as commands. `copy_count` increases by one in the cycle after the last argument byte and changes at no other time.
- R8: A 0xAF received where an operation byte is expected keeps the decoder waiting for an operation byte. Repeated or trailing 0xAF bytes set no error.
- R9: An operation byte other than 0x20, 0x6A or 0xAF, or any byte other than 0xAF where a command must start, sets `proto_err`. Once set, `proto_err` stays 1 until reset. After an unknown operation byte the decoder waits for a new 0xAF.
- R10: A write to an index at or above REG_COUNT (48 by default) that is not 0xFF, or a write to 0xFF with a value other than 0x00 or 0xFF, changes no register, the lock state or `commit`.
- R11: Cycles with `in_valid` low do not advance decoding, so idle gaps between the bytes of a command do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Byte accepted; always 1 |
| act_regs | output | REG_COUNT*8 | Live register bank, register i at bits i*8+7:i*8 |
| depth_sel | output | 8 | Colour-depth selector (0 selects 16 bits per pixel) |
| h_active | output | 16 | Active pixels per line |
| v_active | output | 16 | Active lines |
| pixclk_5k | output | 16 | Pixel clock in 5 kHz units |
| base16 | output | 24 | Base address of the 16 bpp plane |
| base8 | output | 24 | Base address of the 8 bpp plane |
| commit | output | 1 | One-cycle pulse after an unlock |
| proto_err | output | 1 | Sticky protocol error |
| copy_count | output | CNT_W | Number of copy commands consumed |

## Verification
The assertions rely on the byte stream being the only source of change. They also rely on an unlock needing four accepted bytes, so two commit pulses can never fall in adjacent cycles. They do not require well-formed input, because malformed bytes must only raise the sticky flag. The stimulus feeds whole commands, some with idle gaps inside them. Malformed bytes and out-of-range indexes are applied on purpose. A second reset then clears the sticky flag before the idle-state error case is tested.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
    localparam logic [7:0] CMD_MARK   = 8'hAF;
    localparam logic [7:0] OP_REG_WR  = 8'h20;
    localparam logic [7:0] OP_COPY    = 8'h6A;
    localparam logic [7:0] CTRL_INDEX = 8'hFF;
    localparam logic [7:0] CTRL_LOCK  = 8'h00;
    localparam logic [7:0] CTRL_OPEN  = 8'hFF;
    localparam int         COPY_ARGS  = 7;

    localparam int IX_DEPTH  = 'h00;
    localparam int IX_HACT   = 'h0F;
    localparam int IX_VACT   = 'h17;
    localparam int IX_PCLK   = 'h1B;
    localparam int IX_BASE16 = 'h20;
    localparam int IX_BASE8  = 'h26;

    typedef enum logic [2:0] {
        PS_MARK,
        PS_OPCODE,
        PS_INDEX,
        PS_VALUE,
        PS_ARGS
    } parse_st_e;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import disp_cmd_pkg::*;
#(
    parameter int ARG_LEN = COPY_ARGS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_val,
    output logic       copy_done,
    output logic       err_strobe
);
    localparam int LW = $clog2(ARG_LEN + 1);

    typedef struct packed {
        parse_st_e     st;
        logic [7:0]    idx;
        logic [LW-1:0] left;
    } parse_t;

    parse_t p_d, p_q;

    always_comb begin
        p_d        = p_q;
        wr_en      = 1'b0;
        copy_done  = 1'b0;
        err_strobe = 1'b0;
        wr_idx     = p_q.idx;
        wr_val     = byte_in;
        if (byte_vld) begin
            unique case (p_q.st)
                PS_MARK: begin
                    if (byte_in == CMD_MARK) p_d.st = PS_OPCODE;
                    else                     err_strobe = 1'b1;
                end
                PS_OPCODE: begin
                    if (byte_in == CMD_MARK) begin
                        p_d.st = PS_OPCODE;
                    end else if (byte_in == OP_REG_WR) begin
                        p_d.st = PS_INDEX;
                    end else if (byte_in == OP_COPY) begin
                        p_d.st   = PS_ARGS;
                        p_d.left = LW'(ARG_LEN);
                    end else begin
                        p_d.st     = PS_MARK;
                        err_strobe = 1'b1;
                    end
                end
                PS_INDEX: begin
                    p_d.idx = byte_in;
                    p_d.st  = PS_VALUE;
                end
                PS_VALUE: begin
                    wr_en  = 1'b1;
                    p_d.st = PS_MARK;
                end
                PS_ARGS: begin
                    p_d.left = p_q.left - LW'(1);
                    if (p_q.left == LW'(1)) begin
                        copy_done = 1'b1;
                        p_d.st    = PS_MARK;
                    end
                end
                default: p_d.st = PS_MARK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{st: PS_MARK, idx: '0, left: '0};
        else        p_q <= p_d;
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import disp_cmd_pkg::*;
#(
    parameter int REG_COUNT = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             wr_idx,
    input  logic [7:0]             wr_val,
    output logic [REG_COUNT*8-1:0] act_flat,
    output logic                   commit
);
    localparam int IW = $clog2(REG_COUNT);

    typedef struct packed {
        logic                        locked;
        logic                        commit;
        logic [REG_COUNT-1:0][7:0]   shadow;
        logic [REG_COUNT-1:0][7:0]   active;
    } bank_t;

    bank_t b_d, b_q;
    logic  in_range;

    assign in_range = int'(wr_idx) < REG_COUNT;

    always_comb begin
        b_d        = b_q;
        b_d.commit = 1'b0;
        if (wr_en) begin
            if (wr_idx == CTRL_INDEX) begin
                if (wr_val == CTRL_LOCK) begin
                    b_d.locked = 1'b1;
                end else if (wr_val == CTRL_OPEN) begin
                    b_d.locked = 1'b0;
                    b_d.active = b_q.shadow;
                    b_d.commit = 1'b1;
                end
            end else if (in_range) begin
                b_d.shadow[wr_idx[IW-1:0]] = wr_val;
                if (!b_q.locked) b_d.active[wr_idx[IW-1:0]] = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign act_flat = b_q.active;
    assign commit   = b_q.commit;
endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
    import disp_cmd_pkg::*;
#(
    parameter int REG_COUNT = 48,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic [REG_COUNT*8-1:0] act_regs,
    output logic [7:0]             depth_sel,
    output logic [15:0]            h_active,
    output logic [15:0]            v_active,
    output logic [15:0]            pixclk_5k,
    output logic [23:0]            base16,
    output logic [23:0]            base8,
    output logic                   commit,
    output logic                   proto_err,
    output logic [CNT_W-1:0]       copy_count
);
    typedef struct packed {
        logic             err;
        logic [CNT_W-1:0] copies;
    } stat_t;

    logic       fire;
    logic       wr_en;
    logic [7:0] wr_idx;
    logic [7:0] wr_val;
    logic       copy_done;
    logic       err_strobe;
    stat_t      s_d, s_q;

    assign in_ready = 1'b1;
    assign fire     = in_valid & in_ready;

    cmd_parser #(.ARG_LEN(COPY_ARGS)) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (fire),
        .byte_in   (in_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .copy_done (copy_done),
        .err_strobe(err_strobe)
    );

    reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val),
        .act_flat(act_regs),
        .commit  (commit)
    );

    always_comb begin
        s_d = s_q;
        if (err_strobe) s_d.err    = 1'b1;
        if (copy_done)  s_d.copies = s_q.copies + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign proto_err  = s_q.err;
    assign copy_count = s_q.copies;

    // Multi-byte fields; pixel clock is the one stored low byte first.
    assign depth_sel = act_regs[IX_DEPTH*8 +: 8];
    assign h_active  = {act_regs[IX_HACT*8 +: 8], act_regs[(IX_HACT+1)*8 +: 8]};
    assign v_active  = {act_regs[IX_VACT*8 +: 8], act_regs[(IX_VACT+1)*8 +: 8]};
    assign pixclk_5k = {act_regs[(IX_PCLK+1)*8 +: 8], act_regs[IX_PCLK*8 +: 8]};
    assign base16    = {act_regs[IX_BASE16*8 +: 8], act_regs[(IX_BASE16+1)*8 +: 8],
                        act_regs[(IX_BASE16+2)*8 +: 8]};
    assign base8     = {act_regs[IX_BASE8*8 +: 8], act_regs[(IX_BASE8+1)*8 +: 8],
                        act_regs[(IX_BASE8+2)*8 +: 8]};
endmodule

// File: rtl/disp_cmd_checker.sv
module disp_cmd_checker #(
    parameter int REG_COUNT = 48,
    parameter int CNT_W     = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [7:0]             wr_idx,
    input logic [7:0]             wr_val,
    input logic                   copy_done,
    input logic                   err_strobe,
    input logic                   commit,
    input logic                   proto_err,
    input logic [CNT_W-1:0]       copy_count,
    input logic [REG_COUNT*8-1:0] act_regs
);
    a_r4_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(wr_en && wr_idx == 8'hFF && wr_val == 8'hFF));

    a_r4_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(err_strobe));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_count != $past(copy_count)) |->
            (copy_count == $past(copy_count) + CNT_W'(1) && $past(copy_done)));

    a_r10_only_writes_change: assert property (@(posedge clk) disable iff (!rst_n)
        (act_regs != $past(act_regs)) |-> $past(wr_en));
endmodule

bind disp_cmd_decoder disp_cmd_checker #(.REG_COUNT(REG_COUNT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_val    (wr_val),
    .copy_done (copy_done),
    .err_strobe(err_strobe),
    .commit    (commit),
    .proto_err (proto_err),
    .copy_count(copy_count),
    .act_regs  (act_regs)
);

// File: tb/disp_cmd_decoder_bench.sv
module disp_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RC         = 48;
    localparam int CW         = 16;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready;
    logic [RC*8-1:0] act_regs;
    logic [7:0]    depth_sel;
    logic [15:0]   h_active, v_active, pixclk_5k;
    logic [23:0]   base16, base8;
    logic          commit, proto_err;
    logic [CW-1:0] copy_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_cmd_decoder #(.REG_COUNT(RC), .CNT_W(CW)) u_disp_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .act_regs(act_regs), .depth_sel(depth_sel),
        .h_active(h_active), .v_active(v_active), .pixclk_5k(pixclk_5k),
        .base16(base16), .base8(base8), .commit(commit), .proto_err(proto_err),
        .copy_count(copy_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_st, m_left, m_idx, m_cnt;
    logic [7:0] m_sh [256];
    logic [7:0] m_ac [256];
    bit         m_lk, m_cm, m_er;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_idx = 0; m_cnt = 0;
            m_lk = 0; m_cm = 0; m_er = 0;
            for (int i = 0; i < 256; i++) begin
                m_sh[i] = 8'h00;
                m_ac[i] = 8'h00;
            end
        end else begin
            m_cm = 0;
            if (in_valid) begin
                case (m_st)
                    0: if (in_data == 8'hAF) m_st = 1; else m_er = 1;
                    1: begin
                        if (in_data == 8'hAF) m_st = 1;
                        else if (in_data == 8'h20) m_st = 2;
                        else if (in_data == 8'h6A) begin m_st = 4; m_left = 7; end
                        else begin m_er = 1; m_st = 0; end
                    end
                    2: begin m_idx = int'(in_data); m_st = 3; end
                    3: begin
                        m_st = 0;
                        if (m_idx == 255) begin
                            if (in_data == 8'h00) m_lk = 1;
                            else if (in_data == 8'hFF) begin
                                m_lk = 0;
                                m_cm = 1;
                                for (int i = 0; i < 256; i++) m_ac[i] = m_sh[i];
                            end
                        end else if (m_idx < RC) begin
                            m_sh[m_idx] = in_data;
                            if (!m_lk) m_ac[m_idx] = in_data;
                        end
                    end
                    default: begin
                        m_left--;
                        if (m_left == 0) begin m_cnt++; m_st = 0; end
                    end
                endcase
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [RC*8-1:0] exp_flat;
            for (int i = 0; i < RC; i++) exp_flat[i*8 +: 8] = m_ac[i];
            n_chk++;
            if (act_regs !== exp_flat) begin
                n_fail++;
                $display("FAIL R2/R3 live bank actual=%h expected=%h", act_regs, exp_flat);
            end
            chk("R4 commit", 64'(commit), 64'(m_cm));
            chk("R9 proto_err", 64'(proto_err), 64'(m_er));
            chk("R7 copy_count", 64'(copy_count), 64'(m_cnt));
            chk("R5 h_active", 64'(h_active), 64'({m_ac['h0F], m_ac['h10]}));
            chk("R6 pixclk_5k", 64'(pixclk_5k), 64'({m_ac['h1C], m_ac['h1B]}));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
            finish_up();
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic [7:0] b, input int gap = 0);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val, input int gap = 0);
        put(8'hAF, gap); put(8'h20, gap); put(idx, gap); put(val, gap);
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 act_regs zero", 64'(act_regs == '0), 64'd1);
        chk("R1 commit", 64'(commit), 64'd0);
        chk("R1 proto_err", 64'(proto_err), 64'd0);
        chk("R1 copy_count", 64'(copy_count), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);

        // R2 unlocked writes land directly
        wr(8'h00, 8'h01);
        chk("R2 depth_sel", 64'(depth_sel), 64'h01);
        // R5 big-endian fields
        wr(8'h0F, 8'h03); wr(8'h10, 8'h20);
        chk("R5 h_active", 64'(h_active), 64'h0320);
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        chk("R5 base16", 64'(base16), 64'h123456);
        wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
        chk("R5 base8", 64'(base8), 64'hABCDEF);
        // R6 swapped pixel clock
        wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
        chk("R6 pixclk_5k", 64'(pixclk_5k), 64'h1234);

        // R3 lock then stage
        wr(8'hFF, 8'h00);
        wr(8'h17, 8'h02); wr(8'h18, 8'h58); wr(8'h00, 8'h00);
        chk("R3 v_active held", 64'(v_active), 64'h0000);
        chk("R3 depth held", 64'(depth_sel), 64'h01);
        chk("R3 no commit", 64'(commit), 64'd0);
        // R4 unlock applies staged bank
        wr(8'hFF, 8'hFF);
        chk("R4 commit pulse", 64'(commit), 64'd1);
        chk("R4 v_active applied", 64'(v_active), 64'h0258);
        chk("R4 depth applied", 64'(depth_sel), 64'h00);
        settle();
        chk("R4 commit single cycle", 64'(commit), 64'd0);

        // R7 copy command whose arguments look like a register write
        put(8'hAF); put(8'h6A);
        put(8'hAF); put(8'h20); put(8'h00); put(8'h55); put(8'h01); put(8'h00);
        settle();
        chk("R7 count before last arg", 64'(copy_count), 64'd0);
        put(8'h00);
        settle();
        chk("R7 count after copy", 64'(copy_count), 64'd1);
        chk("R7 args not decoded", 64'(depth_sel), 64'h00);

        // R8 repeated and trailing markers
        put(8'hAF); put(8'hAF); put(8'hAF); put(8'h20); put(8'h00); put(8'h07);
        settle();
        chk("R8 write after markers", 64'(depth_sel), 64'h07);
        put(8'hAF);
        settle(); settle();
        chk("R8 trailing marker no error", 64'(proto_err), 64'd0);
        put(8'h20); put(8'h00); put(8'h08);
        settle();
        chk("R8 marker rearms", 64'(depth_sel), 64'h08);

        // R10 ignored writes
        wr(8'h30, 8'h99);
        chk("R10 out-of-range index", 64'(act_regs == {act_regs[RC*8-1:8], 8'h08}), 64'd1);
        wr(8'hFF, 8'h12);
        chk("R10 odd ctrl value no commit", 64'(commit), 64'd0);
        wr(8'h00, 8'h0A);
        chk("R10 lock state unchanged", 64'(depth_sel), 64'h0A);

        // R11 idle gaps inside a command
        wr(8'h0F, 8'h05, 3);
        chk("R11 gapped write", 64'(h_active), 64'h0520);

        // R9 unknown opcode, then recovery
        put(8'hAF); put(8'h33);
        settle();
        chk("R9 unknown opcode", 64'(proto_err), 64'd1);
        wr(8'h00, 8'h09);
        chk("R9 recovers after error", 64'(depth_sel), 64'h09);
        chk("R9 sticky", 64'(proto_err), 64'd1);

        // R9 stray byte where a command starts
        do_reset();
        @(negedge clk);
        chk("R1 err cleared by reset", 64'(proto_err), 64'd0);
        put(8'h55);
        settle();
        chk("R9 stray byte", 64'(proto_err), 64'd1);

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule